// File: doc/BRIEF.md
# OUT Endpoint Receive Packet Buffer

This block is the device-side receive store for one USB OUT endpoint. The link layer streams packet bytes into it, framed by an end-of-packet strobe. Software drains each packet through a byte-wide unload port and then releases it. Storage is one circular byte memory. A two-slot queue beside it records the byte count of every packet held. The block can hold one packet or two, and it tells the link layer whether to acknowledge the next OUT packet or refuse it.

Two-packet operation is used only when it is requested and the memory holds at least two maximum-sized packets. Otherwise the block holds one packet at a time. A packet-ready flag and a full flag report occupancy, and an endpoint interrupt pulses each time a packet becomes available to software. Software clears the ready flag to release the head packet. When auto-release is enabled, a packet of exactly maximum size is released once its last byte is read. A packet longer than the maximum is thrown away and sets a sticky overrun flag.

Top module: `out_ep_rxbuf`

## Requirements
- R1: Two-packet mode is active only when `cfg_dbl_req` is 1 and twice `cfg_max_pkt` is no more than DEPTH (64 by default); otherwise one packet is held and `fifo_full` sets with the first packet.
- R2: In one-packet mode, a stored packet raises `pkt_ready` and `fifo_full` together on the cycle after its end strobe and pulses `ep_irq` for one cycle.
- R3: `hs_ack` is 1 (ACK) while another packet fits and 0 (NAK) otherwise; a packet that starts while it is 0 is discarded and leaves `rd_len` and the stored data untouched.
- R4: A `sw_clr_ready` pulse while `pkt_ready` is set releases the head packet, including any unread bytes; in one-packet mode `pkt_ready` and `fifo_full` drop and `hs_ack` returns to 1.
- R5: With `cfg_auto_clr` at 1, reading the last byte of a packet whose length equals `cfg_max_pkt` releases it with no software write.
- R6: A packet shorter than `cfg_max_pkt` is never auto-released; `pkt_ready` stays 1 after all its bytes are read.
- R7: In two-packet mode, the first packet sets `pkt_ready` and pulses `ep_irq`; a second packet arriving while the first is held sets `fifo_full` with no further interrupt.
- R8: In two-packet mode, releasing the head while `fifo_full` is set gives one cycle with both flags at 0, then `pkt_ready` at 1 with an `ep_irq` pulse and `rd_len` showing the second packet's length.
- R9: `rd_len` shows the head packet's byte count while `pkt_ready` is 1 (0 otherwise). Bytes come out in arrival order on `rd_data` one cycle after `rd_en`. A read past the head packet's length is ignored and `rd_data` holds its value.
- R10: A packet longer than `cfg_max_pkt` is dropped, and `overrun` sets and stays set until a `sw_clr_ovr` pulse. Later packets are stored intact.
- R11: A synchronous `rst` empties the store and length queue and clears `pkt_ready`, `fifo_full` and `overrun`, leaving `hs_ack` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dbl_req | input | 1 | Request two-packet operation |
| cfg_max_pkt | input | 7 | Maximum packet payload in bytes |
| cfg_auto_clr | input | 1 | Auto-release of maximum-sized packets |
| sw_clr_ready | input | 1 | Pulse: release the head packet |
| sw_clr_ovr | input | 1 | Pulse: clear the overrun flag |
| wr_valid | input | 1 | Packet byte present on wr_data |
| wr_data | input | 8 | Packet byte from the link layer |
| wr_eop | input | 1 | End of packet (with or without a byte) |
| rd_en | input | 1 | Unload one byte of the head packet |
| rd_data | output | 8 | Unloaded byte, one cycle after rd_en |
| rd_len | output | 7 | Byte count of the head packet |
| pkt_ready | output | 1 | A packet is available to software |
| fifo_full | output | 1 | No room for another packet |
| overrun | output | 1 | Sticky: an oversized packet was dropped |
| ep_irq | output | 1 | One-cycle endpoint interrupt |
| hs_ack | output | 1 | 1 = ACK next packet, 0 = NAK |

## Verification
The hardest state to reach from the ports is a release issued while two packets are held in two-packet mode. Only that state exercises the one-cycle gap and the re-raised ready flag. The stimulus stores two packets back to back without reading, then offers a third to confirm the refusal. It unloads the first packet, pulses the clear and samples the flags on each of the next two cycles, then unloads the second packet to confirm the read pointer skipped correctly. The overrun path is covered the same way: an oversized packet is followed at once by a short one whose bytes must read back intact.

// File: rtl/oeb_pkg.sv
package oeb_pkg;
  typedef enum logic {BUF_SINGLE = 1'b0, BUF_DOUBLE = 1'b1} buf_mode_e;
  localparam int unsigned SLOTS = 2;
endpackage

// File: rtl/oeb_ram.sv
module oeb_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/oeb_lenq.sv
module oeb_lenq #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [LEN_W-1:0] din,
  output logic [LEN_W-1:0] head,
  output logic [1:0]       count
);
  logic [LEN_W-1:0] slot0_q, slot1_q;
  logic [1:0]       cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot0_q <= '0;
      slot1_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case ({push, pop})
        2'b10: begin
          if (cnt_q == 2'd0) slot0_q <= din;
          else               slot1_q <= din;
          cnt_q <= cnt_q + 2'd1;
        end
        2'b01: begin
          slot0_q <= slot1_q;
          cnt_q   <= cnt_q - 2'd1;
        end
        2'b11: begin
          if (cnt_q == 2'd1) slot0_q <= din;
          else begin
            slot0_q <= slot1_q;
            slot1_q <= din;
          end
        end
        default: ;
      endcase
    end
  end

  assign head  = slot0_q;
  assign count = cnt_q;

  // R7
  lenq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == oeb_pkg::SLOTS[1:0]) |-> (!push || pop));
  // R4
  lenq_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == 2'd0) |-> !pop);
endmodule

// File: rtl/oeb_intake.sv
module oeb_intake #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 7,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              can_accept,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eop,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              commit,
  output logic [LEN_W-1:0]  commit_len,
  output logic              ovr_hit
);
  logic              in_pkt_q, drop_q, ovr_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] wr_ptr_q, wr_base_q;

  logic             start, drop, ovr_prev, ovr_now, live, take;
  logic [LEN_W-1:0] cur;

  always_comb begin
    start    = !in_pkt_q && (wr_valid || wr_eop);
    drop     = start ? !can_accept : drop_q;
    cur      = start ? '0 : cnt_q;
    ovr_prev = start ? 1'b0 : ovr_q;
    live     = wr_valid && !drop;
    take     = live && (cur < max_len);
    ovr_hit  = live && !(cur < max_len);
    ovr_now  = ovr_prev || ovr_hit;
    commit   = wr_eop && !drop && !ovr_now;
    commit_len = cur + LEN_W'(take);
  end

  assign mem_we    = take;
  assign mem_waddr = wr_ptr_q;
  assign mem_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q  <= 1'b0;
      drop_q    <= 1'b0;
      ovr_q     <= 1'b0;
      cnt_q     <= '0;
      wr_ptr_q  <= '0;
      wr_base_q <= '0;
    end else if (start || in_pkt_q) begin
      drop_q   <= drop;
      ovr_q    <= ovr_now;
      cnt_q    <= commit_len;
      wr_ptr_q <= wr_ptr_q + ADDR_W'(take);
      in_pkt_q <= !wr_eop;
      if (wr_eop) begin
        if (commit) wr_base_q <= wr_ptr_q + ADDR_W'(take);
        else        wr_ptr_q  <= wr_base_q;
      end
    end
  end

  // R10
  commit_len_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> (commit_len <= max_len));
  // R3
  nak_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !can_accept) |-> (!mem_we && !commit));
endmodule

// File: rtl/out_ep_rxbuf.sv
module out_ep_rxbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_dbl_req,
  input  logic [LEN_W-1:0]  cfg_max_pkt,
  input  logic              cfg_auto_clr,
  input  logic              sw_clr_ready,
  input  logic              sw_clr_ovr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eop,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LEN_W-1:0]  rd_len,
  output logic              pkt_ready,
  output logic              fifo_full,
  output logic              overrun,
  output logic              ep_irq,
  output logic              hs_ack
);
  import oeb_pkg::*;

  localparam logic [LEN_W:0] DEPTH_V = (LEN_W + 1)'(DEPTH);

  buf_mode_e         mode;
  logic [1:0]        q_cnt, cnt_after;
  logic [LEN_W-1:0]  head_len, commit_len;
  logic              can_accept, commit, ovr_hit;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              ready_q, full_q, rearm_q, irq_q, ovr_q;
  logic [ADDR_W-1:0] rd_ptr_q, rd_base_q, next_base;
  logic [LEN_W-1:0]  rd_cnt_q;
  logic              rd_take, auto_hit, rel;

  // mode choice and intake admission
  always_comb begin
    mode = (cfg_dbl_req && (({1'b0, cfg_max_pkt} << 1) <= DEPTH_V)) ? BUF_DOUBLE : BUF_SINGLE;
    can_accept = (mode == BUF_DOUBLE) ? (q_cnt != 2'd2) : (q_cnt == 2'd0);
  end

  oeb_intake #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_intake (
    .clk(clk), .rst(rst), .max_len(cfg_max_pkt), .can_accept(can_accept),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_eop(wr_eop),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .commit(commit), .commit_len(commit_len), .ovr_hit(ovr_hit)
  );

  oeb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_take), .raddr(rd_ptr_q), .rdata(rd_data)
  );

  oeb_lenq #(.LEN_W(LEN_W)) u_lenq (
    .clk(clk), .rst(rst), .push(commit), .pop(rel), .din(commit_len),
    .head(head_len), .count(q_cnt)
  );

  // unload side
  always_comb begin
    rd_take   = rd_en && ready_q && (rd_cnt_q < head_len);
    auto_hit  = cfg_auto_clr && rd_take && ((rd_cnt_q + LEN_W'(1)) == head_len)
                && (head_len == cfg_max_pkt);
    rel       = ready_q && (sw_clr_ready || auto_hit);
    cnt_after = q_cnt + {1'b0, commit} - {1'b0, rel};
    next_base = rd_base_q + ADDR_W'(head_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr_q  <= '0;
      rd_base_q <= '0;
      rd_cnt_q  <= '0;
    end else if (rel) begin
      rd_ptr_q  <= next_base;
      rd_base_q <= next_base;
      rd_cnt_q  <= '0;
    end else if (rd_take) begin
      rd_ptr_q <= rd_ptr_q + ADDR_W'(1);
      rd_cnt_q <= rd_cnt_q + LEN_W'(1);
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      full_q  <= 1'b0;
      rearm_q <= 1'b0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      irq_q   <= 1'b0;
      rearm_q <= 1'b0;
      if (rel) begin
        ready_q <= 1'b0;
        full_q  <= 1'b0;
        rearm_q <= (cnt_after != 2'd0);
      end else if (commit) begin
        if (q_cnt == 2'd0) begin
          ready_q <= 1'b1;
          irq_q   <= 1'b1;
          full_q  <= (mode == BUF_SINGLE);
        end else begin
          full_q <= 1'b1;
        end
      end
      if (rearm_q) begin
        ready_q <= 1'b1;
        irq_q   <= 1'b1;
      end
      if (ovr_hit)         ovr_q <= 1'b1;
      else if (sw_clr_ovr) ovr_q <= 1'b0;
    end
  end

  assign pkt_ready = ready_q;
  assign fifo_full = full_q;
  assign overrun   = ovr_q;
  assign ep_irq    = irq_q;
  assign hs_ack    = can_accept;
  assign rd_len    = ready_q ? head_len : '0;

  // R2
  full_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    full_q |-> ready_q);
  // R1
  single_one_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == BUF_SINGLE) |-> (q_cnt <= 2'd1));
  // R8
  rearm_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && full_q && sw_clr_ready && mode == BUF_DOUBLE) |=> (!ready_q && !full_q));
  // R8
  rearm_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && full_q && sw_clr_ready && mode == BUF_DOUBLE) |-> ##2 (ready_q && ep_irq));
  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !sw_clr_ovr) |=> ovr_q);
  // R6
  short_no_auto_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !sw_clr_ready && head_len != cfg_max_pkt) |=> ready_q);
endmodule

// File: tb/test_out_ep_rxbuf.sv
module test_out_ep_rxbuf;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 64;
  localparam int LEN_W  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_dbl_req = 1'b0, cfg_auto_clr = 1'b0, sw_clr_ready = 1'b0, sw_clr_ovr = 1'b0;
  logic [LEN_W-1:0] cfg_max_pkt = 7'd16;
  logic wr_valid = 1'b0, wr_eop = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [LEN_W-1:0]  rd_len;
  logic pkt_ready, fifo_full, overrun, ep_irq, hs_ack;

  int checks = 0, errors = 0, irq_cnt = 0;
  logic [DATA_W-1:0] exp_q[$];

  always #2 clk = ~clk;

  out_ep_rxbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_out_ep_rxbuf (
    .clk(clk), .rst(rst), .cfg_dbl_req(cfg_dbl_req), .cfg_max_pkt(cfg_max_pkt),
    .cfg_auto_clr(cfg_auto_clr), .sw_clr_ready(sw_clr_ready), .sw_clr_ovr(sw_clr_ovr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_eop(wr_eop), .rd_en(rd_en),
    .rd_data(rd_data), .rd_len(rd_len), .pkt_ready(pkt_ready), .fifo_full(fifo_full),
    .overrun(overrun), .ep_irq(ep_irq), .hs_ack(hs_ack)
  );

  always @(negedge clk) if (ep_irq === 1'b1) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: pushes expected bytes into the scoreboard when the packet should be kept
  task automatic send_pkt(input int len, input int seed, input bit keep);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = DATA_W'(seed + i);
      wr_eop   = (i == len - 1);
      if (keep) exp_q.push_back(DATA_W'(seed + i));
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_eop   = 1'b0;
  endtask

  // monitor: pops and compares each unloaded byte
  task automatic unload(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] e;
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      e = exp_q.pop_front();
      chk(tag, int'(rd_data), int'(e));
    end
  endtask

  task automatic discard(input int n);
    for (int i = 0; i < n; i++) void'(exp_q.pop_front());
  endtask

  task automatic clear_ready();
    @(negedge clk);
    sw_clr_ready = 1'b1;
    @(negedge clk);
    sw_clr_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [DATA_W-1:0] hold;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 ready after reset", pkt_ready, 0);
    chk("R11 full after reset", fifo_full, 0);
    chk("R11 overrun after reset", overrun, 0);
    chk("R11 hs_ack after reset", hs_ack, 1);
    chk("R11 rd_len after reset", rd_len, 0);

    // single-packet mode
    send_pkt(10, 8'h10, 1'b1);
    chk("R2 ready set", pkt_ready, 1);
    chk("R2 full set", fifo_full, 1);
    chk("R3 hs_ack NAK when held", hs_ack, 0);
    chk("R9 rd_len head", rd_len, 10);
    @(negedge clk);
    chk("R2 irq pulse", irq_cnt, 1);
    send_pkt(6, 8'h80, 1'b0);
    chk("R3 rd_len kept after NAK", rd_len, 10);
    chk("R3 ready kept after NAK", pkt_ready, 1);
    unload(10, "R9 single data");
    hold = rd_data;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 read past end ignored", int'(rd_data), int'(hold));
    chk("R9 rd_len after extra read", rd_len, 10);
    clear_ready();
    chk("R4 ready cleared", pkt_ready, 0);
    chk("R4 full cleared", fifo_full, 0);
    chk("R4 hs_ack restored", hs_ack, 1);

    // auto-release
    cfg_auto_clr = 1'b1;
    send_pkt(16, 8'h20, 1'b1);
    unload(16, "R5 max packet data");
    chk("R5 auto-release", pkt_ready, 0);
    chk("R5 hs_ack after auto-release", hs_ack, 1);
    send_pkt(5, 8'h40, 1'b1);
    unload(5, "R6 short packet data");
    @(negedge clk);
    chk("R6 no auto-release of short packet", pkt_ready, 1);
    clear_ready();
    cfg_auto_clr = 1'b0;

    // double-packet mode
    cfg_dbl_req = 1'b1;
    base = irq_cnt;
    send_pkt(8, 8'h50, 1'b1);
    chk("R7 first ready", pkt_ready, 1);
    chk("R7 first not full", fifo_full, 0);
    chk("R1 double accepts second", hs_ack, 1);
    @(negedge clk);
    chk("R7 first irq", irq_cnt, base + 1);
    send_pkt(12, 8'h60, 1'b1);
    chk("R7 second sets full", fifo_full, 1);
    chk("R7 ready held", pkt_ready, 1);
    chk("R3 NAK when full", hs_ack, 0);
    @(negedge clk);
    chk("R7 no irq for second", irq_cnt, base + 1);
    send_pkt(4, 8'h70, 1'b0);
    chk("R3 rd_len after NAK in double", rd_len, 8);
    unload(8, "R8 first packet data");
    clear_ready();
    chk("R8 gap ready low", pkt_ready, 0);
    chk("R8 gap full low", fifo_full, 0);
    @(negedge clk);
    chk("R8 ready re-raised", pkt_ready, 1);
    chk("R8 rd_len second", rd_len, 12);
    @(negedge clk);
    chk("R8 irq again", irq_cnt, base + 2);
    unload(12, "R8 second packet data");
    clear_ready();
    chk("R4 empty after second", pkt_ready, 0);

    // double requested but max too large
    cfg_max_pkt = 7'd40;
    send_pkt(10, 8'h90, 1'b1);
    chk("R1 falls back to single: full", fifo_full, 1);
    chk("R1 falls back to single: NAK", hs_ack, 0);
    send_pkt(3, 8'hE0, 1'b0);
    unload(10, "R1 single fallback data");
    clear_ready();
    // boundary: 2*32 == DEPTH gives double
    cfg_max_pkt = 7'd32;
    send_pkt(5, 8'hA8, 1'b1);
    chk("R1 boundary double: not full", fifo_full, 0);
    chk("R1 boundary double: ACK", hs_ack, 1);
    clear_ready();
    discard(5);
    chk("R4 release unread packet", pkt_ready, 0);

    // overrun
    cfg_dbl_req = 1'b0;
    cfg_max_pkt = 7'd8;
    send_pkt(12, 8'hA0, 1'b0);
    chk("R10 overrun set", overrun, 1);
    chk("R10 oversized not stored", pkt_ready, 0);
    send_pkt(4, 8'hB0, 1'b1);
    chk("R10 next packet stored", rd_len, 4);
    chk("R10 overrun sticky", overrun, 1);
    unload(4, "R10 data after overrun");
    @(negedge clk);
    sw_clr_ovr = 1'b1;
    @(negedge clk);
    sw_clr_ovr = 1'b0;
    chk("R10 overrun cleared", overrun, 0);
    clear_ready();

    // reset with a packet held
    cfg_max_pkt = 7'd16;
    send_pkt(7, 8'hC0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    chk("R11 ready after mid reset", pkt_ready, 0);
    chk("R11 full after mid reset", fifo_full, 0);
    chk("R11 hs_ack after mid reset", hs_ack, 1);
    chk("R11 rd_len after mid reset", rd_len, 0);
    send_pkt(3, 8'hD0, 1'b1);
    unload(3, "R11 data after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule